// File: doc/BRIEF.md
# Programmable Trigger Interrupt Aggregator

This block gathers thirty-two raw interrupt lines and turns them into two request outputs for a processor. Each line has its own trigger choice: rising edge, falling edge, either edge, active-high level, active-low level, or off. Edges are caught in sticky latches that software clears. Level triggers follow the line directly and are never latched. A per-line enable bit gates the line. A per-line routing bit chooses which of the two request outputs the line feeds.

Software reaches every control register through a small register port. Each register has a set address and a clear address. Writing a one bit at the set address sets that bit. Writing a one bit at the clear address clears it. Zero bits leave the stored value alone. A separate read port returns the current value of any register. Two pending registers show the enabled lines that are requesting on each output.

Raw lines pass through a two-flop synchronizer before edge detection. Each request output is registered.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the three trigger registers and the wake and enable registers read 0. The source and routing registers read all ones. Both edge latches, both pending registers and both request outputs are 0.
- R2: A write address is {register index[3:0], op[1:0]}. Op 1 sets the bits written as one, op 2 clears them, and op 0 or 3 has no effect. The read port takes the register index alone. The indices are: trigger bit 0 = 0, trigger bit 1 = 1, trigger bit 2 = 2, source = 3, routing = 4, wake = 5, enable = 6, rise latch = 7, fall latch = 8, test = 9, pending 0 = 10, pending 1 = 11.
- R3: A line's trigger code is {bit2, bit1, bit0}. With code 001, a rising edge on the synchronized line sets the line's rise latch. The latch keeps the line pending after the input falls. It clears only when a one is written to its bit at the rise-latch clear address, and a zero written there keeps it.
- R4: With code 010, only a falling edge sets the fall latch and makes the line pending. A rising edge leaves both latches and the pending bit at 0.
- R5: With code 011, either edge latches in the latch for that edge, and the line is pending while either latch is set.
- R6: With code 101, the line is pending while the synchronized input is high. The pending bit sets two cycles after the raw input rises and clears when the input falls, with no latch involved.
- R7: With code 110, the line is pending while the synchronized input is low.
- R8: Codes 000, 100 and 111 never make a line pending and never set a latch, whatever the input does.
- R9: A line whose enable bit is 0 appears in neither pending register and raises neither request. Setting the enable bit brings back a level request that is still active.
- R10: A pending, enabled line with routing bit 1 shows in pending 0 and drives request 0. With routing bit 0 it shows in pending 1 and drives request 1.
- R11: Each request output equals the OR of its pending register, delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Raw interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Write address: register index and op |
| wr_data_i | input | 32 | Write data, one bit per line |
| rd_idx_i | input | 4 | Register index for the read port |
| rd_data_o | output | 32 | Current value of the selected register |
| req0_o | output | 1 | Registered request output 0 |
| req1_o | output | 1 | Registered request output 1 |

## Verification
Each trigger code is tried by pulsing its own line up and then down. Reading both latches and the pending registers after each half of the pulse tells the rising, falling and both-edge modes apart, and shows whether a level was latched when it should only follow the input. The off and unused codes get the same pulse with the enable bit set. The enable and routing bits are toggled while a level request is held active. This separates gating from routing and shows both outputs active at once. The request timing is sampled one cycle at a time after a level change, which pins the synchronizer and output register delays.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int IRQC_IDX_W  = 4;
    localparam int IRQC_OP_W   = 2;
    localparam int IRQC_ADDR_W = IRQC_IDX_W + IRQC_OP_W;

    typedef enum logic [IRQC_OP_W-1:0] {
        OP_READ = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_RSVD = 2'd3
    } irqc_op_e;

    typedef enum logic [IRQC_IDX_W-1:0] {
        RI_CFG0   = 4'd0,
        RI_CFG1   = 4'd1,
        RI_CFG2   = 4'd2,
        RI_SRC    = 4'd3,
        RI_ASSIGN = 4'd4,
        RI_WAKE   = 4'd5,
        RI_MASK   = 4'd6,
        RI_RISE   = 4'd7,
        RI_FALL   = 4'd8,
        RI_TEST   = 4'd9,
        RI_PEND0  = 4'd10,
        RI_PEND1  = 4'd11
    } irqc_reg_e;

    localparam logic [2:0] TRIG_OFF  = 3'b000;
    localparam logic [2:0] TRIG_RISE = 3'b001;
    localparam logic [2:0] TRIG_FALL = 3'b010;
    localparam logic [2:0] TRIG_BOTH = 3'b011;
    localparam logic [2:0] TRIG_HIGH = 3'b101;
    localparam logic [2:0] TRIG_LOW  = 3'b110;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= s_i;
    end

    assign rise_o = s_i & ~prev_q;
    assign fall_o = ~s_i & prev_q;
endmodule

// File: rtl/irqc_classify.sv
module irqc_classify
    import irqc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cfg0_i,
    input  logic [W-1:0] cfg1_i,
    input  logic [W-1:0] cfg2_i,
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] rise_q_i,
    input  logic [W-1:0] fall_q_i,
    output logic [W-1:0] rise_arm_o,
    output logic [W-1:0] fall_arm_o,
    output logic [W-1:0] hit_o
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic [2:0] code;
        assign code          = {cfg2_i[i], cfg1_i[i], cfg0_i[i]};
        assign rise_arm_o[i] = (code == TRIG_RISE) || (code == TRIG_BOTH);
        assign fall_arm_o[i] = (code == TRIG_FALL) || (code == TRIG_BOTH);
        assign hit_o[i]      = ((code == TRIG_HIGH) &&  s_i[i])
                             || ((code == TRIG_LOW)  && !s_i[i])
                             || (rise_arm_o[i] && rise_q_i[i])
                             || (fall_arm_o[i] && fall_q_i[i]);
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           irq_i,
    input  logic                   wr_en_i,
    input  logic [IRQC_ADDR_W-1:0] wr_addr_i,
    input  logic [N-1:0]           wr_data_i,
    input  logic [IRQC_IDX_W-1:0]  rd_idx_i,
    output logic [N-1:0]           rd_data_o,
    output logic                   req0_o,
    output logic                   req1_o
);
    typedef struct packed {
        logic [N-1:0] cfg0;
        logic [N-1:0] cfg1;
        logic [N-1:0] cfg2;
        logic [N-1:0] src;
        logic [N-1:0] asg;
        logic [N-1:0] wake;
        logic [N-1:0] mask;
        logic [N-1:0] rise;
        logic [N-1:0] fall;
        logic [N-1:0] test;
        logic         req0;
        logic         req1;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0] sync_s, rise_pulse, fall_pulse;
    logic [N-1:0] rise_arm, fall_arm, hit;
    logic [N-1:0] pend0, pend1;

    irqc_sync #(.W(N), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(irq_i), .q_o(sync_s)
    );

    irqc_edge #(.W(N)) edge_i (
        .clk(clk), .rst_n(rst_n), .s_i(sync_s),
        .rise_o(rise_pulse), .fall_o(fall_pulse)
    );

    irqc_classify #(.W(N)) cls_i (
        .cfg0_i(st_q.cfg0), .cfg1_i(st_q.cfg1), .cfg2_i(st_q.cfg2),
        .s_i(sync_s), .rise_q_i(st_q.rise), .fall_q_i(st_q.fall),
        .rise_arm_o(rise_arm), .fall_arm_o(fall_arm), .hit_o(hit)
    );

    assign pend0 = hit & st_q.mask &  st_q.asg;
    assign pend1 = hit & st_q.mask & ~st_q.asg;

    logic [IRQC_IDX_W-1:0] wr_idx;
    logic [IRQC_OP_W-1:0]  wr_op;
    logic [N-1:0]          set_m, clr_m, rise_clr, fall_clr;

    always_comb begin
        st_d     = st_q;
        wr_idx   = wr_addr_i[IRQC_ADDR_W-1:IRQC_OP_W];
        wr_op    = wr_addr_i[IRQC_OP_W-1:0];
        set_m    = (wr_en_i && wr_op == OP_SET) ? wr_data_i : '0;
        clr_m    = (wr_en_i && wr_op == OP_CLR) ? wr_data_i : '0;
        rise_clr = '0;
        fall_clr = '0;
        case (wr_idx)
            RI_CFG0:   st_d.cfg0 = (st_q.cfg0 | set_m) & ~clr_m;
            RI_CFG1:   st_d.cfg1 = (st_q.cfg1 | set_m) & ~clr_m;
            RI_CFG2:   st_d.cfg2 = (st_q.cfg2 | set_m) & ~clr_m;
            RI_SRC:    st_d.src  = (st_q.src  | set_m) & ~clr_m;
            RI_ASSIGN: st_d.asg  = (st_q.asg  | set_m) & ~clr_m;
            RI_WAKE:   st_d.wake = (st_q.wake | set_m) & ~clr_m;
            RI_MASK:   st_d.mask = (st_q.mask | set_m) & ~clr_m;
            RI_TEST:   st_d.test = (st_q.test | set_m) & ~clr_m;
            RI_RISE:   rise_clr  = clr_m;
            RI_FALL:   fall_clr  = clr_m;
            default:   ;
        endcase
        // a new edge wins over a clear in the same cycle
        st_d.rise = (st_q.rise & ~rise_clr) | (rise_pulse & rise_arm);
        st_d.fall = (st_q.fall & ~fall_clr) | (fall_pulse & fall_arm);
        st_d.req0 = |pend0;
        st_d.req1 = |pend1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.src <= '1;
            st_q.asg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_idx_i)
            RI_CFG0:   rd_data_o = st_q.cfg0;
            RI_CFG1:   rd_data_o = st_q.cfg1;
            RI_CFG2:   rd_data_o = st_q.cfg2;
            RI_SRC:    rd_data_o = st_q.src;
            RI_ASSIGN: rd_data_o = st_q.asg;
            RI_WAKE:   rd_data_o = st_q.wake;
            RI_MASK:   rd_data_o = st_q.mask;
            RI_RISE:   rd_data_o = st_q.rise;
            RI_FALL:   rd_data_o = st_q.fall;
            RI_TEST:   rd_data_o = st_q.test;
            RI_PEND0:  rd_data_o = pend0;
            RI_PEND1:  rd_data_o = pend1;
            default:   rd_data_o = '0;
        endcase
    end

    assign req0_o = st_q.req0;
    assign req1_o = st_q.req1;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int N = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req0_o,
    input logic                   req1_o,
    input logic [N-1:0]           pend0,
    input logic [N-1:0]           pend1,
    input logic [N-1:0]           cfg0,
    input logic [N-1:0]           cfg1,
    input logic [N-1:0]           cfg2,
    input logic [N-1:0]           mask,
    input logic [N-1:0]           rise,
    input logic                   wr_en_i,
    input logic [IRQC_ADDR_W-1:0] wr_addr_i
);
    localparam logic [IRQC_ADDR_W-1:0] RISE_CLR_ADDR = {RI_RISE, OP_CLR};

    AST_ROUTE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend0 & pend1) == '0); // R10

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> (!req0_o && !req1_o)); // R9

    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req0_o) |-> $past(|pend0)); // R11

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend0 | pend1) & ~(cfg0 | cfg1 | cfg2)) == '0); // R8

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(rise) & ~rise)) |-> ($past(wr_en_i) && $past(wr_addr_i) == RISE_CLR_ADDR)); // R3
endmodule

bind evt_irq_ctrl irqc_chk #(.N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .req0_o(req0_o), .req1_o(req1_o),
    .pend0(pend0), .pend1(pend1),
    .cfg0(st_q.cfg0), .cfg1(st_q.cfg1), .cfg2(st_q.cfg2),
    .mask(st_q.mask), .rise(st_q.rise),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
    import irqc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N-1:0]           irq = '0;
    logic                   wr_en = 1'b0;
    logic [IRQC_ADDR_W-1:0] wr_addr = '0;
    logic [N-1:0]           wr_data = '0;
    logic [IRQC_IDX_W-1:0]  rd_idx = '0;
    logic [N-1:0]           rd_data;
    logic                   req0, req1;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .req0_o(req0), .req1_o(req1)
    );

    typedef struct {
        bit                    is_req;
        logic [IRQC_IDX_W-1:0] idx;
        logic [N-1:0]          exp;
        string                 tag;
    } item_t;

    item_t exp_q[$];
    int    pending_items = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // monitor: pops each expected item and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [N-1:0] act;
            wait (pending_items > 0);
            it = exp_q.pop_front();
            if (!it.is_req) rd_idx = it.idx;
            #1;
            act = it.is_req ? {{(N-2){1'b0}}, req1, req0} : rd_data;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
            pending_items--;
        end
    end

    task automatic expect_reg(input irqc_reg_e idx, input logic [N-1:0] exp, input string tag);
        item_t it;
        it.is_req = 0; it.idx = idx; it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        pending_items++;
        wait (pending_items == 0);
    endtask

    task automatic expect_req(input logic [1:0] exp, input string tag);
        item_t it;
        it.is_req = 1; it.idx = '0; it.exp = {{(N-2){1'b0}}, exp}; it.tag = tag;
        exp_q.push_back(it);
        pending_items++;
        wait (pending_items == 0);
    endtask

    task automatic wr(input irqc_reg_e idx, input irqc_op_e op, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {idx, op}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cleanup();
        wr(RI_CFG0, OP_CLR, '1);
        wr(RI_CFG1, OP_CLR, '1);
        wr(RI_CFG2, OP_CLR, '1);
        wr(RI_MASK, OP_CLR, '1);
        wr(RI_ASSIGN, OP_SET, '1);
        irq = '0;
        cyc(4);
        wr(RI_RISE, OP_CLR, '1);
        wr(RI_FALL, OP_CLR, '1);
        cyc(1);
    endtask

    localparam logic [N-1:0] B3  = 32'h1 << 3;
    localparam logic [N-1:0] B5  = 32'h1 << 5;
    localparam logic [N-1:0] B7  = 32'h1 << 7;
    localparam logic [N-1:0] B9  = 32'h1 << 9;
    localparam logic [N-1:0] B12 = 32'h1 << 12;
    localparam logic [N-1:0] B14 = 32'h1 << 14;

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        expect_reg(RI_CFG0, '0, "R1 cfg0");
        expect_reg(RI_CFG1, '0, "R1 cfg1");
        expect_reg(RI_CFG2, '0, "R1 cfg2");
        expect_reg(RI_WAKE, '0, "R1 wake");
        expect_reg(RI_MASK, '0, "R1 mask");
        expect_reg(RI_SRC, '1, "R1 source");
        expect_reg(RI_ASSIGN, '1, "R1 routing");
        expect_reg(RI_RISE, '0, "R1 rise latch");
        expect_reg(RI_FALL, '0, "R1 fall latch");
        expect_reg(RI_PEND0, '0, "R1 pend0");
        expect_reg(RI_PEND1, '0, "R1 pend1");
        expect_req(2'b00, "R1 requests");

        // R2 set / clear / read addressing
        wr(RI_WAKE, OP_SET, 32'h0000_00F0);
        expect_reg(RI_WAKE, 32'h0000_00F0, "R2 set");
        wr(RI_WAKE, OP_SET, 32'h0000_000F);
        expect_reg(RI_WAKE, 32'h0000_00FF, "R2 set keeps zeros");
        wr(RI_WAKE, OP_CLR, 32'h0000_0030);
        expect_reg(RI_WAKE, 32'h0000_00CF, "R2 clear");
        wr(RI_WAKE, OP_RSVD, 32'hFFFF_0000);
        wr(RI_WAKE, OP_READ, 32'hFFFF_0000);
        expect_reg(RI_WAKE, 32'h0000_00CF, "R2 op0/op3 no effect");
        wr(RI_SRC, OP_CLR, 32'h0000_FFFF);
        expect_reg(RI_SRC, 32'hFFFF_0000, "R2 source clear");
        wr(RI_TEST, OP_SET, 32'h0000_0001);
        expect_reg(RI_TEST, 32'h0000_0001, "R2 test set");
        wr(RI_TEST, OP_CLR, 32'h0000_0001);
        expect_reg(RI_TEST, '0, "R2 test clear");
        wr(RI_WAKE, OP_CLR, '1);
        wr(RI_SRC, OP_SET, '1);

        // R3 rising edge, sticky
        wr(RI_CFG0, OP_SET, B3);
        wr(RI_MASK, OP_SET, B3);
        irq[3] = 1'b1;
        cyc(4);
        expect_reg(RI_RISE, B3, "R3 latch set");
        expect_reg(RI_PEND0, B3, "R3 pending");
        expect_req(2'b01, "R3 request");
        irq[3] = 1'b0;
        cyc(4);
        expect_reg(RI_PEND0, B3, "R3 sticky after fall");
        expect_reg(RI_FALL, '0, "R3 no fall latch");
        wr(RI_RISE, OP_CLR, '0);
        expect_reg(RI_RISE, B3, "R3 zero clear keeps");
        wr(RI_RISE, OP_CLR, B3);
        expect_reg(RI_PEND0, '0, "R3 cleared");
        cyc(1);
        expect_req(2'b00, "R3 request drops");
        cleanup();

        // R4 falling edge only
        wr(RI_CFG1, OP_SET, B5);
        wr(RI_MASK, OP_SET, B5);
        irq[5] = 1'b1;
        cyc(4);
        expect_reg(RI_PEND0, '0, "R4 rise ignored");
        expect_reg(RI_RISE, '0, "R4 no rise latch");
        irq[5] = 1'b0;
        cyc(4);
        expect_reg(RI_FALL, B5, "R4 fall latch");
        expect_reg(RI_PEND0, B5, "R4 pending");
        wr(RI_FALL, OP_CLR, B5);
        expect_reg(RI_PEND0, '0, "R4 cleared");
        cleanup();

        // R5 both edges
        wr(RI_CFG0, OP_SET, B7);
        wr(RI_CFG1, OP_SET, B7);
        wr(RI_MASK, OP_SET, B7);
        irq[7] = 1'b1;
        cyc(4);
        expect_reg(RI_RISE, B7, "R5 rise latch");
        expect_reg(RI_PEND0, B7, "R5 pending on rise");
        wr(RI_RISE, OP_CLR, B7);
        expect_reg(RI_PEND0, '0, "R5 cleared");
        irq[7] = 1'b0;
        cyc(4);
        expect_reg(RI_FALL, B7, "R5 fall latch");
        expect_reg(RI_PEND0, B7, "R5 pending on fall");
        cleanup();

        // R6 high level, R11 latency
        wr(RI_CFG0, OP_SET, B9);
        wr(RI_CFG2, OP_SET, B9);
        wr(RI_MASK, OP_SET, B9);
        irq[9] = 1'b1;
        cyc(2);
        expect_reg(RI_PEND0, B9, "R6 pending after sync");
        expect_req(2'b00, "R11 request not yet");
        cyc(1);
        expect_req(2'b01, "R11 request one cycle later");
        expect_reg(RI_RISE, '0, "R6 not latched");
        irq[9] = 1'b0;
        cyc(2);
        expect_reg(RI_PEND0, '0, "R6 follows input low");

        // R9 enable gating
        wr(RI_MASK, OP_CLR, B9);
        irq[9] = 1'b1;
        cyc(4);
        expect_reg(RI_PEND0, '0, "R9 masked pend0");
        expect_reg(RI_PEND1, '0, "R9 masked pend1");
        expect_req(2'b00, "R9 masked request");
        wr(RI_MASK, OP_SET, B9);
        expect_reg(RI_PEND0, B9, "R9 unmask pending");
        cyc(1);
        expect_req(2'b01, "R9 unmask request");

        // R10 routing
        wr(RI_ASSIGN, OP_CLR, B9);
        expect_reg(RI_PEND1, B9, "R10 routed to pend1");
        expect_reg(RI_PEND0, '0, "R10 gone from pend0");
        cyc(1);
        expect_req(2'b10, "R10 request 1");
        wr(RI_CFG1, OP_SET, B12);
        wr(RI_CFG2, OP_SET, B12);
        wr(RI_MASK, OP_SET, B12);
        cyc(1);
        expect_reg(RI_PEND0, B12, "R10 routing 1 to pend0");
        expect_req(2'b11, "R10 both requests");
        cleanup();

        // R7 low level
        wr(RI_CFG1, OP_SET, B12);
        wr(RI_CFG2, OP_SET, B12);
        wr(RI_MASK, OP_SET, B12);
        expect_reg(RI_PEND0, B12, "R7 pending while low");
        irq[12] = 1'b1;
        cyc(4);
        expect_reg(RI_PEND0, '0, "R7 idle while high");
        expect_reg(RI_RISE, '0, "R7 not latched");
        irq[12] = 1'b0;
        cyc(4);
        expect_reg(RI_PEND0, B12, "R7 pending again");
        cleanup();

        // R8 off and unused codes
        wr(RI_MASK, OP_SET, B14);
        irq[14] = 1'b1;
        cyc(4);
        expect_reg(RI_PEND0, '0, "R8 code 000");
        expect_reg(RI_RISE, '0, "R8 code 000 no latch");
        wr(RI_CFG2, OP_SET, B14);
        expect_reg(RI_PEND0, '0, "R8 code 100");
        wr(RI_CFG1, OP_SET, B14);
        wr(RI_CFG0, OP_SET, B14);
        expect_reg(RI_PEND0, '0, "R8 code 111 high");
        irq[14] = 1'b0;
        cyc(4);
        expect_reg(RI_PEND0, '0, "R8 code 111 low");
        expect_reg(RI_FALL, '0, "R8 code 111 no latch");
        expect_req(2'b00, "R8 no request");
        cleanup();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule